// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Chain

This block collects interrupt requests from a row of devices and settles which one the processor serves when it acknowledges. There is one stage per device. A stage latches its device's request pulse into a pending flag. Any pending flag pulls a shared active-low request line toward the processor. That line is modelled as a wired-OR of the stages.

The acknowledge enters the stage with index 0 and travels down the chain. A stage with nothing pending hands the grant on to the next stage. A stage with a pending flag keeps the grant and blocks everything behind it. So position alone sets priority, and index 0 ranks highest. The stage that holds the grant puts its device's vector address on the vector bus and raises the valid signal.

After the grant has been held for a short, fixed delay, the stage clears its own flag. If the processor keeps the acknowledge high, the grant then moves on to the next pending stage. The grant that leaves the last stage is brought out, so a further chain can be cascaded behind this one.

Top module: `irq_daisy_chain`

## Requirements
- R1: While reset is held, and after it is released, every pending flag is clear, `irq_n_o` is 1, `vec_valid_o` is 0, `vec_o` is 0 and `chain_po_o` follows `ack_i`.
- R2: A device whose `dev_req_i` bit is 1 at a rising clock edge becomes pending from that edge. Its flag stays set without an acknowledge even after the request returns to 0.
- R3: While `ack_i` is 1, the lowest-index pending stage owns the grant in the same cycle. `vec_o` then equals that device's slice of `dev_vec_i` (bits `i*VEC_W` and up), `vec_valid_o` is 1, and no more than one stage owns the grant at a time.
- R4: While `ack_i` is 0, `vec_valid_o` is 0 and `vec_o` is 0, whatever flags are pending.
- R5: The first cycle a stage owns the grant is cycle n. Its flag is cleared by the edge that ends cycle n+1. With `ack_i` still 1, the grant passes to the next pending stage from cycle n+2.
- R6: `irq_n_o` is 0 while at least one flag is pending, and it is 1 once all flags are clear.
- R7: A request that arrives on the same edge that would clear that stage's flag wins, so the flag stays set. The stage can then be granted and cleared again through the normal sequence.
- R8: A stage with no pending flag passes the grant on unchanged. `chain_po_o` is 1 exactly when `ack_i` is 1 and no stage is pending. A device that is pending behind idle stages still receives the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req_i | input | N_DEV | Per-device request, sampled at each rising edge |
| dev_vec_i | input | N_DEV*VEC_W | Per-device vector addresses, device i in slice i |
| ack_i | input | 1 | Processor acknowledge, the grant entering stage 0 |
| irq_n_o | output | 1 | Combined active-low interrupt request |
| vec_o | output | VEC_W | Vector of the grant owner, zero when nobody owns |
| vec_valid_o | output | 1 | A stage owns the grant and `vec_o` is valid |
| chain_po_o | output | 1 | Grant leaving the last stage, for cascading |

## Verification
The hardest case to reach is a request that lands on the very edge that clears a flag. It needs the request to arrive exactly two edges after the grant was first taken. The bench gets there by holding the acknowledge high and counting edges. It raises the request again in cycle n+1, then drops the acknowledge and checks that the flag survived and can be granted again. A handover of the grant between two pending stages is also driven, under one continuous acknowledge, with the second vector expected in the predicted cycle.

// File: rtl/irq_chain_pkg.sv
// Package: shared types for the daisy-chain interrupt block.
// Assumes nothing beyond the 1800-2017 language.
package irq_chain_pkg;

    // What a stage does with the grant arriving at its priority input.
    typedef enum logic [1:0] {
        GRANT_ABSENT  = 2'd0,  // no grant arriving
        GRANT_PASS    = 2'd1,  // grant arrives, stage idle, forward it
        GRANT_CAPTURE = 2'd2   // grant arrives, stage pending, keep it
    } grant_act_e;

endpackage

// File: rtl/irq_stage.sv
// Module: one stage of the daisy chain.
// Latches its device request into a pending flag.
// Forwards the incoming grant when idle and captures it when pending.
// Gates its vector onto the shared bus while it captures.
// Clears the flag one clock after the first captured cycle.
// A request on the clearing edge takes precedence over the clear.
// Assumes a synchronous, active-low reset and a request sampled at each edge.
module irq_stage
    import irq_chain_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             pi_i,
    output logic             po_o,
    output logic             own_o,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o
);

    logic       flag_q;
    logic       taken_q;
    grant_act_e act;

    // Decide what happens to the incoming grant.
    always_comb begin
        if (!pi_i)       act = GRANT_ABSENT;
        else if (flag_q) act = GRANT_CAPTURE;
        else             act = GRANT_PASS;
    end

    // Drive the priority output, the ownership flag and the gated vector.
    always_comb begin
        po_o   = (act == GRANT_PASS);
        own_o  = (act == GRANT_CAPTURE);
        pend_o = flag_q;
        vec_o  = own_o ? vec_i : '0;
    end

    // One-shot marker: set after the first owned cycle, then self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n) taken_q <= 1'b0;
        else        taken_q <= own_o && !taken_q;
    end

    // Pending flag: a request sets it, the delayed marker clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (req_i)   flag_q <= 1'b1;
        else if (taken_q) flag_q <= 1'b0;
    end

    // R7: a sampled request always leaves the flag set.
    a_r7_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> flag_q);

    // R5: the delayed clear takes effect when no new request competes.
    a_r5_delayed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_q && !req_i) |=> !flag_q);

endmodule

// File: rtl/irq_vec_merge.sv
// Module: wired-OR merge of the stage vectors and ownership bits.
// Assumes the stages drive zero when they do not own the grant.
module irq_vec_merge #(
    parameter int N_DEV = 4,
    parameter int VEC_W = 8
) (
    input  logic [N_DEV-1:0]       own_i,
    input  logic [N_DEV*VEC_W-1:0] vec_i,
    output logic [VEC_W-1:0]       vec_o,
    output logic                   valid_o
);

    // OR every gated vector onto the shared bus.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N_DEV; i++) begin
            vec_o = vec_o | vec_i[i*VEC_W +: VEC_W];
        end
        valid_o = |own_i;
    end

endmodule

// File: rtl/irq_daisy_chain.sv
// Module: top of the daisy-chain interrupt priority block.
// Builds N_DEV stages in series, with stage 0 fed by the acknowledge.
// Merges the stage vectors and forms the active-low combined request.
// Assumes requests and acknowledge are synchronous to clk.
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int N_DEV = 4,
    parameter int VEC_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DEV-1:0]       dev_req_i,
    input  logic [N_DEV*VEC_W-1:0] dev_vec_i,
    input  logic                   ack_i,
    output logic                   irq_n_o,
    output logic [VEC_W-1:0]       vec_o,
    output logic                   vec_valid_o,
    output logic                   chain_po_o
);

    localparam int BUS_W = N_DEV * VEC_W;

    logic [N_DEV:0]     grant;
    logic [N_DEV-1:0]   own;
    logic [N_DEV-1:0]   pend;
    logic [BUS_W-1:0]   gated;

    assign grant[0] = ack_i;

    // One stage per device, each wired to the grant of the stage before it.
    for (genvar g = 0; g < N_DEV; g++) begin : g_stage
        irq_stage #(.VEC_W(VEC_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (dev_req_i[g]),
            .vec_i  (dev_vec_i[g*VEC_W +: VEC_W]),
            .pi_i   (grant[g]),
            .po_o   (grant[g+1]),
            .own_o  (own[g]),
            .pend_o (pend[g]),
            .vec_o  (gated[g*VEC_W +: VEC_W])
        );
    end

    irq_vec_merge #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_merge (
        .own_i   (own),
        .vec_i   (gated),
        .vec_o   (vec_o),
        .valid_o (vec_valid_o)
    );

    // Inverting wired-OR of the pending flags onto the request line.
    always_comb begin
        irq_n_o    = ~(|pend);
        chain_po_o = grant[N_DEV];
    end

    // R3: the grant is owned by no more than one stage.
    a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own));

    // R4: without acknowledge the bus is idle and zero.
    a_r4_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> (!vec_valid_o && vec_o == '0));

    // R8: with nothing pending, the grant runs through the whole chain.
    a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend == '0) |-> chain_po_o);

endmodule

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;

    localparam int N_DEV = 4;
    localparam int VEC_W = 8;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [N_DEV-1:0]       dev_req_i;
    logic [N_DEV*VEC_W-1:0] dev_vec_i;
    logic                   ack_i;
    logic                   irq_n_o;
    logic [VEC_W-1:0]       vec_o;
    logic                   vec_valid_o;
    logic                   chain_po_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_daisy_chain #(.N_DEV(N_DEV), .VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .dev_req_i(dev_req_i), .dev_vec_i(dev_vec_i),
        .ack_i(ack_i), .irq_n_o(irq_n_o), .vec_o(vec_o),
        .vec_valid_o(vec_valid_o), .chain_po_o(chain_po_o)
    );

    function automatic logic [VEC_W-1:0] vec_of(int i);
        return VEC_W'(8'hA0 + i);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge, one rising edge later.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bus(string req, bit valid, logic [VEC_W-1:0] v,
                             bit irqn, bit po);
        #1;
        chk({req, " valid"}, 32'(vec_valid_o), 32'(valid));
        chk({req, " vector"}, 32'(vec_o), 32'(v));
        chk({req, " irq_n"}, 32'(irq_n_o), 32'(irqn));
        chk({req, " po"}, 32'(chain_po_o), 32'(po));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; dev_req_i = '0; ack_i = 1'b0;
        step(); step();
        check_bus("R1 in reset", 0, '0, 1, 0);
        rst_n = 1'b1;
        step();
        check_bus("R1 after reset", 0, '0, 1, 0);
        ack_i = 1'b1;
        check_bus("R1 po follows ack", 0, '0, 1, 1);
        ack_i = 1'b0;
    endtask

    task automatic t_single();
        dev_req_i = 4'b0100;
        step();
        dev_req_i = '0;
        step(); step();
        check_bus("R2 held pending / R4 no ack", 0, '0, 0, 0);
        ack_i = 1'b1;
        check_bus("R3 R8 device 2 owns", 1, vec_of(2), 0, 0);
        step();
        check_bus("R5 still owned cycle n+1", 1, vec_of(2), 0, 0);
        step();
        check_bus("R5 R6 cleared", 0, '0, 1, 1);
        ack_i = 1'b0;
        step();
    endtask

    task automatic t_priority();
        dev_req_i = 4'b1010;
        step();
        dev_req_i = '0;
        ack_i = 1'b1;
        check_bus("R3 device 1 beats 3", 1, vec_of(1), 0, 0);
        step(); step();
        check_bus("R5 grant moves to 3 / R6", 1, vec_of(3), 0, 0);
        step(); step();
        check_bus("R6 all clear", 0, '0, 1, 1);
        ack_i = 1'b0;
        step();
    endtask

    task automatic t_set_wins();
        dev_req_i = 4'b0001;
        step();
        dev_req_i = '0;
        ack_i = 1'b1;
        check_bus("R3 device 0 owns", 1, vec_of(0), 0, 0);
        step();
        dev_req_i = 4'b0001;
        step();
        dev_req_i = '0;
        ack_i = 1'b0;
        check_bus("R7 flag survived", 0, '0, 0, 0);
        step();
        check_bus("R7 still pending", 0, '0, 0, 0);
        ack_i = 1'b1;
        check_bus("R7 granted again", 1, vec_of(0), 0, 0);
        step(); step();
        check_bus("R7 R5 cleared again", 0, '0, 1, 1);
        ack_i = 1'b0;
        step();
    endtask

    task automatic t_no_ack_many();
        dev_req_i = 4'b1111;
        step();
        dev_req_i = '0;
        step();
        check_bus("R4 all pending no ack", 0, '0, 0, 0);
        ack_i = 1'b1;
        for (int i = 0; i < N_DEV; i++) begin
            check_bus("R3 R5 sequence", 1, vec_of(i), 0, 0);
            step(); step();
        end
        check_bus("R6 R8 drained", 0, '0, 1, 1);
        ack_i = 1'b0;
        step();
    endtask

    initial begin
        for (int i = 0; i < N_DEV; i++) dev_vec_i[i*VEC_W +: VEC_W] = vec_of(i);
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_set_wins();
        t_no_ack_many();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule